// File: doc/BRIEF.md
# Heartbeat Watchdog with Stretched Reset

This block watches a processor heartbeat line and drives an active-low reset back to the processor when the heartbeat stops. Each falling edge on the heartbeat line restarts a cycle-counted timer. If the timer runs a full timeout period without seeing such an edge, the reset output drops at once. It then stays low for a fixed number of clock cycles and is released. While the reset is low, the timer is held cleared and heartbeat edges are discarded. Timing starts afresh on the cycle the reset is released.

A second, active-high enable output tracks the health of the heartbeat over a longer horizon. It drops when three timeouts occur in a row with no accepted heartbeat edge between them. It rises again after three accepted edges in a row, each of which by construction arrived within one timeout. A synchronous power-on reset makes the block issue one full reset pulse before it starts timing.

Top module: `hb_watchdog`

## Requirements
- R1: With no accepted heartbeat falling edge, `rst_n_out` goes low exactly `TIMEOUT_CYC` clock cycles after the timer was last cleared. An edge sampled on the `TIMEOUT_CYC`-th cycle still counts as in time. An edge spacing of `TIMEOUT_CYC+1` fires the reset.
- R2: Once low, `rst_n_out` stays low for exactly `PULSE_CYC` cycles and then returns high.
- R3: A heartbeat falling edge sampled while `rst_n_out` is high clears the timer. Edges spaced at most `TIMEOUT_CYC` cycles apart keep `rst_n_out` high indefinitely.
- R4: While `rst_n_out` is low, the timer stays cleared and heartbeat falling edges are ignored. Such edges change neither the pulse length nor the next timeout, and they do not count toward enable recovery.
- R5: Timing restarts on the release of the reset. With no heartbeat, the next reset fires `TIMEOUT_CYC` cycles after `rst_n_out` rose.
- R6: `ena_out` drops on the same cycle as the third consecutive timeout firing with no accepted edge between them. A single accepted edge restarts that count, so two misses, then an edge, then two misses leave `ena_out` high.
- R7: With `ena_out` low, the third consecutive accepted heartbeat edge raises `ena_out` on the cycle that edge is sampled. A timeout between the edges restarts the count.
- R8: While `srst` is high, `rst_n_out` is low and `ena_out` is high. After `srst` falls, `rst_n_out` stays low for `PULSE_CYC` cycles before timing begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| hb_in | input | 1 | Heartbeat line; falling edges are the keep-alive |
| rst_n_out | output | 1 | Reset to the processor, active low |
| ena_out | output | 1 | Enable output, high while the heartbeat is healthy |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 16 and `PULSE_CYC` = 8. These values keep each timeout and pulse short enough to count every cycle of them one by one. A run can therefore place edges exactly on the last cycle of a timeout and one cycle past it, and fit three heartbeat edges inside a single reset pulse. They also make chains of three consecutive timeouts cheap, so both the enable drop and its recovery, with a counter reset in between, fit well inside the run.

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned PULSE_CYC   = 200,
  parameter int unsigned MISS_LIMIT  = 3,
  parameter int unsigned GOOD_LIMIT  = 3
) (
  input  logic clk,
  input  logic srst,
  input  logic hb_in,
  output logic rst_n_out,
  output logic ena_out
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam int GW = $clog2(GOOD_LIMIT + 1);

  logic          hb_q;
  logic          holding;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tmr;
  logic [MW-1:0] miss;
  logic [GW-1:0] good;
  logic          ena;

  wire hb_fall  = hb_q & ~hb_in;
  wire expired  = (tmr == TW'(TIMEOUT_CYC - 1));
  wire pulse_end = (pcnt == PW'(PULSE_CYC - 1));

  always_ff @(posedge clk) begin
    if (srst) begin
      hb_q    <= 1'b1;
      holding <= 1'b1;
      pcnt    <= '0;
      tmr     <= '0;
      miss    <= '0;
      good    <= '0;
      ena     <= 1'b1;
    end else begin
      hb_q <= hb_in;
      if (holding) begin
        tmr <= '0;
        if (pulse_end) begin
          holding <= 1'b0;
          pcnt    <= '0;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end else if (hb_fall) begin
        tmr  <= '0;
        miss <= '0;
        if (!ena) begin
          if (good == GW'(GOOD_LIMIT - 1)) begin
            ena  <= 1'b1;
            good <= '0;
          end else begin
            good <= good + 1'b1;
          end
        end
      end else if (expired) begin
        holding <= 1'b1;
        pcnt    <= '0;
        tmr     <= '0;
        good    <= '0;
        if (miss < MW'(MISS_LIMIT)) miss <= miss + 1'b1;
        if (miss >= MW'(MISS_LIMIT - 1)) ena <= 1'b0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  assign rst_n_out = ~holding;
  assign ena_out   = ena;

  assert_fire_on_expiry_R1: assert property (@(posedge clk) disable iff (srst)
    (rst_n_out && expired && !hb_fall) |=> !rst_n_out);

  assert_pulse_held_R2: assert property (@(posedge clk) disable iff (srst)
    (!rst_n_out && !pulse_end) |=> !rst_n_out);

  assert_edge_clears_R3: assert property (@(posedge clk) disable iff (srst)
    (rst_n_out && hb_fall) |=> (tmr == '0 && rst_n_out));

  assert_timer_frozen_R4: assert property (@(posedge clk) disable iff (srst)
    !rst_n_out |=> (tmr == '0));

  assert_restart_on_release_R5: assert property (@(posedge clk) disable iff (srst)
    $rose(rst_n_out) |-> (tmr == '0));

  assert_ena_drop_with_fire_R6: assert property (@(posedge clk) disable iff (srst)
    $fell(ena_out) |-> $fell(rst_n_out));

  assert_ena_rise_on_edge_R7: assert property (@(posedge clk) disable iff (srst)
    $rose(ena_out) |-> $past(hb_fall && rst_n_out));
endmodule

// File: tb/hb_watchdog_tb_top.sv
`timescale 1ns/1ps
module hb_watchdog_tb_top;
  localparam int T = 16;
  localparam int P = 8;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic hb_in = 1'b1;
  logic rst_n_out, ena_out;
  int vecs = 0;
  int errs = 0;

  always #4 clk = ~clk;

  hb_watchdog #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .MISS_LIMIT(3), .GOOD_LIMIT(3)) dut_i (
    .clk(clk), .srst(srst), .hb_in(hb_in), .rst_n_out(rst_n_out), .ena_out(ena_out));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Called at a negedge just after the timer was cleared; fall sampled n edges later.
  task automatic hb_fall_at(input int n);
    repeat (n - 1) @(negedge clk);
    hb_in = 1'b0;
    @(negedge clk);
    hb_in = 1'b1;
  endtask

  // From a negedge right after the timer cleared: full timeout, then full pulse.
  task automatic fire_and_release(input string req);
    repeat (T - 1) @(negedge clk);
    chk(req, "rst_n before expiry", rst_n_out, 1'b1);
    @(negedge clk);
    chk(req, "rst_n at expiry", rst_n_out, 1'b0);
    repeat (P - 1) @(negedge clk);
    chk(req, "rst_n late in pulse", rst_n_out, 1'b0);
    @(negedge clk);
    chk(req, "rst_n after pulse", rst_n_out, 1'b1);
  endtask

  task automatic t_power_on();
    srst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "rst_n in srst", rst_n_out, 1'b0);
    chk("R8", "ena in srst", ena_out, 1'b1);
    srst = 1'b0;
    for (int i = 0; i < P - 1; i++) begin
      @(negedge clk);
      chk("R8", "rst_n power-on pulse", rst_n_out, 1'b0);
    end
    @(negedge clk);
    chk("R8", "rst_n after power-on pulse", rst_n_out, 1'b1);
    chk("R8", "ena after power-on", ena_out, 1'b1);
  endtask

  task automatic t_keepalive();
    for (int i = 0; i < 6; i++) begin
      hb_fall_at(T);
      chk("R1", "edge on last cycle keeps rst_n", rst_n_out, 1'b1);
    end
    for (int i = 0; i < 6; i++) begin
      hb_fall_at(3 + i);
      chk("R3", "short spacing keeps rst_n", rst_n_out, 1'b1);
    end
    hb_fall_at(T + 1);
    chk("R1", "spacing T+1 fires", rst_n_out, 1'b0);
    repeat (P - 1) @(negedge clk);
    chk("R2", "rst_n after late-edge pulse", rst_n_out, 1'b1);
    hb_fall_at(4);
    chk("R3", "edge after release", rst_n_out, 1'b1);
  endtask

  task automatic t_miss_chain();
    fire_and_release("R2");
    chk("R6", "ena after one miss", ena_out, 1'b1);
    repeat (T - 1) @(negedge clk);
    chk("R5", "rst_n T-1 after release", rst_n_out, 1'b1);
    @(negedge clk);
    chk("R5", "rst_n T after release", rst_n_out, 1'b0);
    chk("R6", "ena after two misses", ena_out, 1'b1);
    for (int i = 0; i < 3; i++) hb_fall_at(2);
    @(negedge clk);
    chk("R4", "rst_n with edges in pulse", rst_n_out, 1'b0);
    @(negedge clk);
    chk("R4", "pulse length with edges", rst_n_out, 1'b1);
    repeat (T - 1) @(negedge clk);
    chk("R4", "timer not moved by ignored edges", rst_n_out, 1'b1);
    chk("R6", "ena before third miss", ena_out, 1'b1);
    @(negedge clk);
    chk("R4", "full timeout after release", rst_n_out, 1'b0);
    chk("R6", "ena at third miss", ena_out, 1'b0);
  endtask

  task automatic t_recover();
    for (int i = 0; i < 3; i++) hb_fall_at(2);
    repeat (2) @(negedge clk);
    chk("R2", "release after pulse", rst_n_out, 1'b1);
    chk("R4", "ignored edges did not recover ena", ena_out, 1'b0);
    hb_fall_at(5);
    chk("R7", "ena after one good edge", ena_out, 1'b0);
    hb_fall_at(5);
    chk("R7", "ena after two good edges", ena_out, 1'b0);
    fire_and_release("R7");
    hb_fall_at(5);
    chk("R7", "count restarted by timeout", ena_out, 1'b0);
    hb_fall_at(5);
    chk("R7", "second edge after restart", ena_out, 1'b0);
    hb_fall_at(5);
    chk("R7", "ena on third good edge", ena_out, 1'b1);
    chk("R3", "rst_n during recovery", rst_n_out, 1'b1);
  endtask

  task automatic t_miss_cleared();
    fire_and_release("R6");
    fire_and_release("R6");
    hb_fall_at(3);
    fire_and_release("R6");
    fire_and_release("R6");
    chk("R6", "ena after 2 misses, edge, 2 misses", ena_out, 1'b1);
    repeat (T) @(negedge clk);
    chk("R6", "rst_n third miss after edge", rst_n_out, 1'b0);
    chk("R6", "ena at third miss after edge", ena_out, 1'b0);
  endtask

  initial begin
    t_power_on();
    t_keepalive();
    t_miss_chain();
    t_recover();
    t_miss_cleared();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule